// File: doc/BRIEF.md
# Data Address Breakpoint Unit

This unit sits beside a processor's load/store path and watches every data access. When an access matches a programmed watch address and its type is allowed by that watch point's enable, the unit raises a breakpoint pulse for the debug logic. The access itself is never held back or cancelled. The pulse arrives in the cycle after the access is presented.

Two 32-bit watch registers and one configuration register are written and read through a small register port. Watch register 1 has two modes. It can be a second watch address with its own enable. It can also be a don't-care mask that turns watch register 0 into an address range.

Each cycle the unit takes one access descriptor: a valid flag, a byte address, a size code, an access kind, and an exclusion flag. The exclusion flag marks preload hints and cache or TLB maintenance operations.

Top module: `data_brk_unit`

## Requirements
- R1: After reset, both watch registers and the configuration register read as zero, and `hit` and `hit_src` are low.
- R2: Register select 0 holds watch address 0 and select 1 holds watch address 1. Both are read back in full. Select 2 is the configuration register: bit 8 is the mode, bits 3:2 are enable 1, and bits 1:0 are enable 0. All its other bits read as zero, and writes to them are dropped. Select 3 reads zero and ignores writes.
- R3: Each 2-bit enable is decoded as follows: 00 off, 01 stores only, 10 any access, 11 loads only. Access kinds are 0 load, 1 store and 2 swap.
- R4: A swap access (kind 2) is a store. It fires under "stores only" and "any", and never under "loads only".
- R5: An access with `acc_excl` high, or with the reserved kind 3, never produces a hit.
- R6: Size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. An aligned access hits if any byte address it covers equals the watch address.
- R7: An access whose address is not a multiple of its size is compared as if it started at the address rounded down to a word boundary. It covers that many bytes from there.
- R8: With mode = 1, every bit set in watch register 1 is excluded from the compare against watch register 0. Enable 1 has no effect, watch register 1 never reports a hit, and nothing fires while enable 0 is off.
- R9: With mode = 0, watch register 1 matches on its own under enable 1. `hit_src` bit 0 flags watch register 0 and bit 1 flags watch register 1, and both may be set at once.
- R10: `hit` is high for exactly the one cycle after a matching valid access is presented. `hit_src` is nonzero only in that cycle. An access with `acc_valid` low never hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 watch 0, 1 watch 1, 2 configuration) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, combinational |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Size code (0 byte, 1 half, 2/3 word) |
| acc_kind | input | 2 | Access kind (0 load, 1 store, 2 swap, 3 reserved) |
| acc_excl | input | 1 | Excluded operation (preload or maintenance) |
| hit | output | 1 | Registered one-cycle breakpoint pulse |
| hit_src | output | 2 | Watch registers that matched, valid with `hit` |

## Verification
The bench targets the lane arithmetic. It checks word and halfword accesses whose target byte is not the first byte covered, and unaligned halfwords that must be folded down to the word base. A design that compared only the start address, or that rounded the wrong way, would miss these hits or report false ones.

It also checks mode switching. A design that let enable 1 act in mask mode, or that let the mask apply with enable 0 off, would fire on accesses that must stay silent. The other targeted cases are swaps under a loads-only setting, excluded operations under "any access", and the requirement that `hit` drops after a single cycle.

Randomized accesses are aimed close to the programmed addresses, so that near misses and masked ranges are compared against a byte-by-byte reference model.

// File: rtl/dbu_pkg.sv
// Shared types for the data address breakpoint unit.
// Assumes a 4-byte data word; field positions of the configuration word are fixed.
package dbu_pkg;

    typedef enum logic [1:0] {
        EN_OFF   = 2'b00,
        EN_STORE = 2'b01,
        EN_ANY   = 2'b10,
        EN_LOAD  = 2'b11
    } dbu_en_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_SWAP  = 2'b10,
        KIND_RSVD  = 2'b11
    } dbu_kind_e;

    typedef struct packed {
        logic    mode;   // 1: watch register 1 is a mask for watch register 0
        dbu_en_e en1;
        dbu_en_e en0;
    } dbu_cfg_t;

    localparam logic [1:0] SEL_WATCH0 = 2'd0;
    localparam logic [1:0] SEL_WATCH1 = 2'd1;
    localparam logic [1:0] SEL_CFG    = 2'd2;

    localparam int CFG_MODE_BIT = 8;

endpackage

// File: rtl/dbu_regs.sv
// Register file: two watch addresses and the configuration word.
// Assumes writes take effect on the next clock; reads are combinational.
module dbu_regs
    import dbu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] watch0,
    output logic [DW-1:0] watch1,
    output dbu_cfg_t      cfg
);

    // Register update on writes; unused configuration bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch0 <= '0;
            watch1 <= '0;
            cfg    <= '{mode: 1'b0, en1: EN_OFF, en0: EN_OFF};
        end else if (wr_en) begin
            case (sel)
                SEL_WATCH0: watch0 <= wdata;
                SEL_WATCH1: watch1 <= wdata;
                SEL_CFG: begin
                    cfg.mode <= wdata[CFG_MODE_BIT];
                    cfg.en1  <= dbu_en_e'(wdata[3:2]);
                    cfg.en0  <= dbu_en_e'(wdata[1:0]);
                end
                default: ;
            endcase
        end
    end

    // Read mux; reserved configuration bits are returned as zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_WATCH0: rdata = watch0;
            SEL_WATCH1: rdata = watch1;
            SEL_CFG: begin
                rdata[CFG_MODE_BIT] = cfg.mode;
                rdata[3:2]          = cfg.en1;
                rdata[1:0]          = cfg.en0;
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbu_lanes.sv
// Byte lane decoder: marks the lanes of the data word covered by an access.
// An access not aligned to its own size is folded down to the word base.
module dbu_lanes #(
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LW-1:0]    low_addr,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lane_mask
);

    int bytes_i;
    int start_i;

    // Byte count and first covered lane of the access.
    always_comb begin
        case (size)
            2'd0:    bytes_i = 1;
            2'd1:    bytes_i = 2;
            default: bytes_i = 4;
        endcase
        if (bytes_i > LANES) bytes_i = LANES;
        if ((int'(low_addr) & (bytes_i - 1)) == 0) start_i = int'(low_addr);
        else                                       start_i = 0;
    end

    // One covered flag per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = (g >= start_i) && (g < start_i + bytes_i);
    end

endmodule

// File: rtl/dbu_cmp.sv
// One watch channel: access type filter plus masked address compare per byte lane.
// Assumes lane_mask comes from dbu_lanes; ignore bits set to 1 are don't-care.
module dbu_cmp
    import dbu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 4,
    localparam int LW   = $clog2(LANES)
) (
    input  logic             valid,
    input  logic             excl,
    input  dbu_kind_e        kind,
    input  dbu_en_e          en,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_mask,
    input  logic [AW-1:0]    watch,
    input  logic [AW-1:0]    ignore,
    output logic             match
);

    logic             type_ok;
    logic             upper_ok;
    logic [LANES-1:0] lane_hit;

    // Access kind filter; swaps count as stores, reserved kind never passes.
    always_comb begin
        case (en)
            EN_STORE: type_ok = (kind == KIND_STORE) || (kind == KIND_SWAP);
            EN_ANY:   type_ok = (kind != KIND_RSVD);
            EN_LOAD:  type_ok = (kind == KIND_LOAD);
            default:  type_ok = 1'b0;
        endcase
    end

    // Word-select compare on the bits above the lane index.
    assign upper_ok = (((addr[AW-1:LW] ^ watch[AW-1:LW]) & ~ignore[AW-1:LW]) == '0);

    // Lane compare: a covered lane whose index equals the watched byte (under mask).
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign lane_hit[g] = lane_mask[g] &&
                             (((LW'(g) ^ watch[LW-1:0]) & ~ignore[LW-1:0]) == '0);
    end

    assign match = valid && !excl && type_ok && upper_ok && (|lane_hit);

endmodule

// File: rtl/data_brk_unit.sv
// Data address breakpoint unit top: register file, lane decoder and two
// watch channels; the hit result is registered into a one-cycle pulse.
// Assumes a register write and an access in the same cycle see the old settings.
module data_brk_unit
    import dbu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LANES = 4,
    parameter int NCH   = 2,
    localparam int LW   = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic [1:0]    acc_kind,
    input  logic          acc_excl,
    output logic          hit,
    output logic [1:0]    hit_src
);

    logic [AW-1:0]    watch0;
    logic [AW-1:0]    watch1;
    dbu_cfg_t         cfg;
    logic [LANES-1:0] lane_mask;
    logic [NCH-1:0]   ch_match;

    dbu_regs #(.DW(AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .watch0 (watch0),
        .watch1 (watch1),
        .cfg    (cfg)
    );

    dbu_lanes #(.LANES(LANES)) u_lanes (
        .low_addr  (acc_addr[LW-1:0]),
        .size      (acc_size),
        .lane_mask (lane_mask)
    );

    // Channel 0 uses watch 1 as its mask in mask mode; channel 1 is silenced then.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dbu_en_e       ch_en;
        logic [AW-1:0] ch_watch;
        logic [AW-1:0] ch_ignore;
        if (c == 0) begin : g_primary
            assign ch_en     = cfg.en0;
            assign ch_watch  = watch0;
            assign ch_ignore = cfg.mode ? watch1 : '0;
        end else begin : g_second
            assign ch_en     = cfg.mode ? EN_OFF : cfg.en1;
            assign ch_watch  = watch1;
            assign ch_ignore = '0;
        end
        dbu_cmp #(.AW(AW), .LANES(LANES)) u_cmp (
            .valid     (acc_valid),
            .excl      (acc_excl),
            .kind      (dbu_kind_e'(acc_kind)),
            .en        (ch_en),
            .addr      (acc_addr),
            .lane_mask (lane_mask),
            .watch     (ch_watch),
            .ignore    (ch_ignore),
            .match     (ch_match[c])
        );
    end

    // Registered breakpoint pulse and source flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            hit_src <= '0;
        end else begin
            hit     <= |ch_match;
            hit_src <= ch_match;
        end
    end

endmodule

// File: rtl/data_brk_unit_chk.sv
// Property checker for data_brk_unit, attached with bind below.
module data_brk_unit_chk
    import dbu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_excl,
    input logic [1:0]  acc_kind,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_rdata,
    input logic        hit,
    input logic [1:0]  hit_src,
    input dbu_cfg_t    cfg
);

    // R10: a pulse needs a valid access one cycle earlier
    a_r10_hit_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(acc_valid));

    // R10: source flags appear only together with the pulse
    a_r10_src_with_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (hit_src != 2'b00));

    // R5: excluded or reserved accesses never fire
    a_r5_excluded_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_excl || acc_kind == 2'b11)) |=> !hit);

    // R8: in mask mode watch register 1 never reports
    a_r8_mask_no_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg.mode) |=> !hit_src[1]);

    // R8: in mask mode nothing fires while enable 0 is off
    a_r8_mask_needs_en0: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg.mode && cfg.en0 == EN_OFF) |=> !hit);

    // R4: a swap never trips a loads-only watch 0
    a_r4_swap_not_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b10 && cfg.en0 == EN_LOAD) |=> !hit_src[0]);

    // R2: reserved configuration bits read zero
    a_r2_cfg_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_CFG) |-> (reg_rdata[31:9] == '0 && reg_rdata[7:4] == '0));

endmodule

bind data_brk_unit data_brk_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_excl  (acc_excl),
    .acc_kind  (acc_kind),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .hit       (hit),
    .hit_src   (hit_src),
    .cfg       (cfg)
);

// File: tb/data_brk_unit_tb.sv
`timescale 1ns/1ps
module data_brk_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_excl = 1'b0;
    logic        hit;
    logic [1:0]  hit_src;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m_w0 = '0, m_w1 = '0;
    logic        m_mode = 1'b0;
    logic [1:0]  m_en0 = '0, m_en1 = '0;

    always #2 clk = ~clk;

    data_brk_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
        .acc_excl(acc_excl), .hit(hit), .hit_src(hit_src)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Reference for one channel: walk every covered byte address.
    function automatic bit ref_chan(input logic [31:0] a, input logic [1:0] sz,
                                    input logic [1:0] kd, input bit ex,
                                    input logic [31:0] w, input logic [31:0] ign,
                                    input logic [1:0] en);
        int n;
        logic [31:0] base;
        bit type_ok;
        if (ex || kd == 2'd3) return 0;
        case (en)
            2'd1:    type_ok = (kd != 2'd0);
            2'd2:    type_ok = 1;
            2'd3:    type_ok = (kd == 2'd0);
            default: type_ok = 0;
        endcase
        if (!type_ok) return 0;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        base = ((a % n) == 0) ? a : (a & ~32'd3);
        for (int i = 0; i < n; i++) begin
            if ((((base + i) ^ w) & ~ign) == 0) return 1;
        end
        return 0;
    endfunction

    function automatic logic [1:0] ref_src(input logic [31:0] a, input logic [1:0] sz,
                                           input logic [1:0] kd, input bit ex);
        logic [1:0] r;
        r[0] = ref_chan(a, sz, kd, ex, m_w0, m_mode ? m_w1 : 32'd0, m_en0);
        r[1] = m_mode ? 1'b0 : ref_chan(a, sz, kd, ex, m_w1, 32'd0, m_en1);
        return r;
    endfunction

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        case (s)
            2'd0: m_w0 = d;
            2'd1: m_w1 = d;
            2'd2: begin m_mode = d[8]; m_en1 = d[3:2]; m_en0 = d[1:0]; end
            default: ;
        endcase
    endtask

    task automatic rd(input string tag, input logic [1:0] s, input logic [31:0] exp);
        reg_sel = s;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic cfg(input bit mode, input logic [1:0] e1, input logic [1:0] e0);
        wr(2'd2, {23'd0, mode, 4'd0, e1, e0});
    endtask

    // Present one access, then check the pulse one cycle later.
    task automatic acc(input string tag, input bit v, input logic [31:0] a,
                       input logic [1:0] sz, input logic [1:0] kd, input bit ex,
                       input logic [1:0] exp_src);
        acc_valid = v; acc_addr = a; acc_size = sz; acc_kind = kd; acc_excl = ex;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({tag, " hit"}, {31'd0, hit}, {31'd0, |exp_src});
        chk({tag, " src"}, {30'd0, hit_src}, {30'd0, exp_src});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 hit", {31'd0, hit}, 32'd0);
        chk("R1 src", {30'd0, hit_src}, 32'd0);
        rd("R1 watch0", 2'd0, 32'd0);
        rd("R1 watch1", 2'd1, 32'd0);
        rd("R1 cfg", 2'd2, 32'd0);

        // R2: readback and reserved bits
        wr(2'd2, 32'hFFFF_FFFF);
        rd("R2 cfg reserved", 2'd2, 32'h0000_010F);
        wr(2'd0, 32'hDEAD_BEEF);
        rd("R2 watch0", 2'd0, 32'hDEAD_BEEF);
        wr(2'd1, 32'h1234_5678);
        rd("R2 watch1", 2'd1, 32'h1234_5678);
        wr(2'd3, 32'hFFFF_FFFF);
        rd("R2 sel3", 2'd3, 32'd0);
        rd("R2 watch0 untouched", 2'd0, 32'hDEAD_BEEF);

        // R3: enable encodings on watch 0
        wr(2'd0, 32'h0000_1000);
        wr(2'd1, 32'h0000_9000);
        cfg(0, 2'd0, 2'd0);
        acc("R3 off", 1, 32'h1000, 2'd2, 2'd0, 0, 2'b00);
        cfg(0, 2'd0, 2'd1);
        acc("R3 store-only load", 1, 32'h1000, 2'd2, 2'd0, 0, 2'b00);
        acc("R3 store-only store", 1, 32'h1000, 2'd2, 2'd1, 0, 2'b01);
        cfg(0, 2'd0, 2'd3);
        acc("R3 load-only load", 1, 32'h1000, 2'd2, 2'd0, 0, 2'b01);
        acc("R3 load-only store", 1, 32'h1000, 2'd2, 2'd1, 0, 2'b00);
        // R4: swap as store
        acc("R4 swap load-only", 1, 32'h1000, 2'd0, 2'd2, 0, 2'b00);
        cfg(0, 2'd0, 2'd1);
        acc("R4 swap store-only", 1, 32'h1000, 2'd0, 2'd2, 0, 2'b01);
        // R5: excluded and reserved kinds
        cfg(0, 2'd0, 2'd2);
        acc("R5 excluded", 1, 32'h1000, 2'd2, 2'd0, 1, 2'b00);
        acc("R5 reserved kind", 1, 32'h1000, 2'd2, 2'd3, 0, 2'b00);

        // R6: any covered byte
        wr(2'd0, 32'h0000_1003);
        acc("R6 word covers lane3", 1, 32'h1000, 2'd2, 2'd0, 0, 2'b01);
        acc("R6 half low misses", 1, 32'h1000, 2'd1, 2'd0, 0, 2'b00);
        acc("R6 half high hits", 1, 32'h1002, 2'd1, 2'd0, 0, 2'b01);
        acc("R6 byte exact", 1, 32'h1003, 2'd0, 2'd0, 0, 2'b01);
        acc("R6 next word", 1, 32'h1004, 2'd2, 2'd0, 0, 2'b00);
        // R7: unaligned folded to word base
        wr(2'd0, 32'h0000_1001);
        acc("R7 unaligned half folds", 1, 32'h1003, 2'd1, 2'd0, 0, 2'b01);
        wr(2'd0, 32'h0000_1003);
        acc("R7 unaligned half no lane3", 1, 32'h1003, 2'd1, 2'd0, 0, 2'b00);
        acc("R7 unaligned word", 1, 32'h1001, 2'd2, 2'd0, 0, 2'b01);

        // R8: mask mode
        wr(2'd0, 32'h0000_2000);
        wr(2'd1, 32'h0000_00F0);
        cfg(1, 2'd2, 2'd2);
        acc("R8 masked range hit", 1, 32'h20A0, 2'd0, 2'd0, 0, 2'b01);
        acc("R8 outside range", 1, 32'h2100, 2'd0, 2'd0, 0, 2'b00);
        acc("R8 watch1 not a target", 1, 32'h00F0, 2'd0, 2'd0, 0, 2'b00);
        cfg(1, 2'd2, 2'd0);
        acc("R8 en0 off", 1, 32'h20A0, 2'd0, 2'd0, 0, 2'b00);
        cfg(1, 2'd0, 2'd3);
        acc("R8 en1 ignored", 1, 32'h20F0, 2'd0, 2'd0, 0, 2'b01);

        // R9: two independent watches
        wr(2'd0, 32'h0000_3000);
        wr(2'd1, 32'h0000_3002);
        cfg(0, 2'd2, 2'd2);
        acc("R9 both", 1, 32'h3000, 2'd2, 2'd1, 0, 2'b11);
        cfg(0, 2'd3, 2'd0);
        acc("R9 watch1 alone", 1, 32'h3002, 2'd0, 2'd0, 0, 2'b10);
        acc("R9 watch1 own type", 1, 32'h3002, 2'd0, 2'd1, 0, 2'b00);

        // R10: pulse length and valid gating
        cfg(0, 2'd0, 2'd2);
        acc("R10 hit", 1, 32'h3000, 2'd0, 2'd0, 0, 2'b01);
        acc("R10 drops after one", 0, 32'h3000, 2'd0, 2'd0, 0, 2'b00);
        acc("R10 invalid", 0, 32'h3000, 2'd0, 2'd0, 0, 2'b00);

        // Random sweep aimed near the programmed addresses (R6 R7 R8 R9)
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] a;
            logic [1:0]  sz, kd;
            bit          ex;
            if (it % 40 == 0) begin
                wr(2'd0, $urandom);
                wr(2'd1, ($urandom % 2) ? ($urandom & 32'h0000_00FF) : $urandom);
                wr(2'd2, $urandom);
            end
            a  = (($urandom % 2) ? m_w0 : m_w1) ^ ($urandom & 32'h0000_0007);
            sz = 2'($urandom);
            kd = 2'($urandom);
            ex = (($urandom % 8) == 0);
            acc("R6 random", 1, a, sz, kd, ex, ref_src(a, sz, kd, ex));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule